// File: doc/BRIEF.md
# ADC Result Window Comparator

This block watches the stream of finished conversion results from an analog-to-digital converter and compares each new result, as it arrives, against two programmable bounds: a lower-trip bound (`lt`) and an upper-trip bound (`gt`). When a result meets the window condition, a sticky hit flag is latched. The flag can be polled, or it can raise an interrupt request through an enable input. No processor involvement is needed per sample.

There is no mode bit. The relative order of the two bounds selects the detection sense:
- If the lower-trip bound is numerically above the upper-trip bound, the block reports results strictly between the two bounds (inside mode).
- Otherwise it reports results strictly below the lower-trip bound or strictly above the upper-trip bound (outside mode).

Each bound arrives as an upper part and a low byte, which the block joins into one comparison value. The flag is held by a two-state machine:
- `WF_QUIET`: the flag is low.
- `WF_TRIPPED`: the flag is high.

The machine has three transitions:
- HIT: `WF_QUIET` to `WF_TRIPPED` when a valid result matches.
- ACK: `WF_TRIPPED` to `WF_QUIET` on a clear strobe with no match in the same cycle.
- HOLD: the state is kept in every other case.

Top module: `adc_window_watch`

## Requirements
- R1: After reset, `hit_flag` and `irq_req` are 0.
- R2: Each bound is the concatenation {hi, lo}: the `*_hi` port gives bits W-1:8 and the `*_lo` port gives bits 7:0.
- R3: Inside mode applies when the lower-trip bound is greater than the upper-trip bound. A valid result matches when upper-trip < result < lower-trip.
- R4: Outside mode applies when the lower-trip bound is less than or equal to the upper-trip bound. A valid result matches when result < lower-trip or result > upper-trip.
- R5: A cycle with `res_valid`=1 and a matching result makes `hit_flag` 1 after the next rising clock edge (HIT).
- R6: Once set, `hit_flag` stays 1 until a clear, including through later non-matching results (HOLD).
- R7: `flag_clr`=1 without a match in the same cycle makes `hit_flag` 0 after the edge (ACK). If a clear and a match occur in the same cycle, the flag ends up 1.
- R8: A result presented with `res_valid`=0 never sets the flag, even if it would match.
- R9: `irq_req` equals `hit_flag` AND `irq_en`, combinationally, with no added latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_valid | input | 1 | New conversion result strobe |
| res_data | input | W | Conversion result, unsigned |
| gt_hi | input | W-8 | Upper-trip bound, upper bits |
| gt_lo | input | 8 | Upper-trip bound, low byte |
| lt_hi | input | W-8 | Lower-trip bound, upper bits |
| lt_lo | input | 8 | Lower-trip bound, low byte |
| flag_clr | input | 1 | Clear strobe for the hit flag |
| irq_en | input | 1 | Interrupt enable |
| hit_flag | output | 1 | Sticky window hit flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The bench sweeps every 12-bit result value against six bound pairs:
- Equal bounds, where outside mode must report every value except the shared bound. A design that treated equality as inside mode would flag nothing there.
- Bounds at the extremes 0 and 4095, where inside mode reports all interior values and outside mode reports none. An off-by-one or non-strict compare would flag the endpoints.

Each sweep step asserts a clear together with the next result. This checks that the set wins over the clear, which a clear-priority design would lose by dropping every flag. Separate steps check the following:
- Stickiness through a non-matching result.
- An ignored result presented without its strobe.
- A byte-boundary bound that catches a swapped or misaligned byte join.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;
    typedef enum logic {
        WF_QUIET   = 1'b0,
        WF_TRIPPED = 1'b1
    } wflag_state_e;

    typedef enum logic {
        WSENSE_OUTSIDE = 1'b0,
        WSENSE_INSIDE  = 1'b1
    } wsense_e;
endpackage

// File: rtl/wcmp_limit_join.sv
module wcmp_limit_join #(
    parameter int W    = 12,
    parameter int LO_W = 8,
    localparam int HI_W = W - LO_W
) (
    input  logic [HI_W-1:0] part_hi,
    input  logic [LO_W-1:0] part_lo,
    output logic [W-1:0]    joined
);
    always_comb begin
        joined = {part_hi, part_lo};
    end
endmodule

// File: rtl/wcmp_window_cmp.sv
module wcmp_window_cmp
    import wcmp_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sample,
    input  logic [W-1:0] bound_gt,
    input  logic [W-1:0] bound_lt,
    output wsense_e      sense,
    output logic         hit
);
    logic above_gt;
    logic below_lt;

    always_comb begin
        above_gt = sample > bound_gt;
        below_lt = sample < bound_lt;
        sense    = (bound_lt > bound_gt) ? WSENSE_INSIDE : WSENSE_OUTSIDE;
        unique case (sense)
            WSENSE_INSIDE:  hit = above_gt && below_lt;
            WSENSE_OUTSIDE: hit = above_gt || below_lt;
            default:        hit = 1'b0;
        endcase
    end

    // R3
    inside_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && sense == WSENSE_INSIDE) |-> (sample != bound_gt && sample != bound_lt));
    // R4
    outside_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == WSENSE_OUTSIDE && bound_gt == bound_lt && sample != bound_gt) |-> hit);
endmodule

// File: rtl/wcmp_flag_fsm.sv
module wcmp_flag_fsm
    import wcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic hit,
    input  logic clr,
    output logic flag
);
    wflag_state_e state_q;
    wflag_state_e state_d;
    logic         set_now;

    assign set_now = strobe && hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WF_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WF_QUIET:   if (set_now) state_d = WF_TRIPPED;
            WF_TRIPPED: if (clr && !set_now) state_d = WF_QUIET;
            default:    state_d = WF_QUIET;
        endcase
    end

    always_comb begin
        flag = (state_q == WF_TRIPPED);
    end

    // R5
    set_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && hit) |=> flag);
    // R6
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    // R7
    clear_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(strobe && hit)) |=> !flag);
    // R8
    no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(strobe && hit)) |=> !flag);
endmodule

// File: rtl/adc_window_watch.sv
module adc_window_watch
    import wcmp_pkg::*;
#(
    parameter int W = 12,
    localparam int LO_W = 8,
    localparam int HI_W = W - LO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            res_valid,
    input  logic [W-1:0]    res_data,
    input  logic [HI_W-1:0] gt_hi,
    input  logic [LO_W-1:0] gt_lo,
    input  logic [HI_W-1:0] lt_hi,
    input  logic [LO_W-1:0] lt_lo,
    input  logic            flag_clr,
    input  logic            irq_en,
    output logic            hit_flag,
    output logic            irq_req
);
    logic [W-1:0] bound_gt;
    logic [W-1:0] bound_lt;
    wsense_e      sense;
    logic         hit;

    wcmp_limit_join #(.W(W), .LO_W(LO_W)) u_join_gt (
        .part_hi(gt_hi), .part_lo(gt_lo), .joined(bound_gt)
    );
    wcmp_limit_join #(.W(W), .LO_W(LO_W)) u_join_lt (
        .part_hi(lt_hi), .part_lo(lt_lo), .joined(bound_lt)
    );

    wcmp_window_cmp #(.W(W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .sample(res_data),
        .bound_gt(bound_gt), .bound_lt(bound_lt),
        .sense(sense), .hit(hit)
    );

    wcmp_flag_fsm u_flag (
        .clk(clk), .rst_n(rst_n), .strobe(res_valid),
        .hit(hit), .clr(flag_clr), .flag(hit_flag)
    );

    always_comb begin
        irq_req = hit_flag && irq_en;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !hit_flag);
endmodule

// File: tb/adc_window_watch_bench.sv
module adc_window_watch_bench;
    localparam int W = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          res_valid = 1'b0;
    logic [W-1:0]  res_data = '0;
    logic [W-9:0]  gt_hi = '0;
    logic [7:0]    gt_lo = '0;
    logic [W-9:0]  lt_hi = '0;
    logic [7:0]    lt_lo = '0;
    logic          flag_clr = 1'b0;
    logic          irq_en = 1'b0;
    logic          hit_flag;
    logic          irq_req;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #10 clk = ~clk;

    adc_window_watch #(.W(W)) u_adc_window_watch (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .gt_hi(gt_hi), .gt_lo(gt_lo), .lt_hi(lt_hi), .lt_lo(lt_lo),
        .flag_clr(flag_clr), .irq_en(irq_en),
        .hit_flag(hit_flag), .irq_req(irq_req)
    );

    task automatic check(input string req, input logic act, input logic exp, input int v);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s value=%0d actual=%b expected=%b", req, v, act, exp);
        end
    endtask

    task automatic set_bounds(input int g, input int l);
        gt_hi = g[W-1:8]; gt_lo = g[7:0];
        lt_hi = l[W-1:8]; lt_lo = l[7:0];
    endtask

    function automatic logic expect_hit(input int v, input int g, input int l);
        if (l > g) return (v > g) && (v < l);
        return (v < l) || (v > g);
    endfunction

    task automatic step(input logic vld, input int v, input logic clr);
        res_valid = vld; res_data = v[W-1:0]; flag_clr = clr;
        @(posedge clk);
        @(negedge clk);
        res_valid = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic sweep(input int g, input int l);
        string req;
        logic e;
        req = (l > g) ? "R3" : "R4";
        set_bounds(g, l);
        step(1'b0, 0, 1'b1);
        for (int v = 0; v < (1 << W); v++) begin
            irq_en = v[0];
            step(1'b1, v, 1'b1);
            e = expect_hit(v, g, l);
            check(req, hit_flag, e, v);
            check("R9", irq_req, e & v[0], v);
        end
        irq_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", hit_flag, 1'b0, 0);
        check("R1", irq_req, 1'b0, 0);
        rst_n = 1'b1;
        @(negedge clk);

        sweep(100, 200);
        sweep(200, 100);
        sweep(500, 500);
        sweep(0, 4095);
        sweep(4095, 0);
        sweep(0, 0);

        // R2: gt = 0x100, lt = 0x258 -> inside (256, 600)
        set_bounds(256, 600);
        step(1'b0, 0, 1'b1);
        step(1'b1, 256, 1'b0);
        check("R2", hit_flag, 1'b0, 256);
        step(1'b1, 257, 1'b0);
        check("R2", hit_flag, 1'b1, 257);
        check("R5", hit_flag, 1'b1, 257);
        // R6: non-matching result, no clear
        step(1'b1, 700, 1'b0);
        check("R6", hit_flag, 1'b1, 700);
        step(1'b0, 0, 1'b0);
        check("R6", hit_flag, 1'b1, 0);
        // R7: clear without match
        step(1'b0, 300, 1'b1);
        check("R7", hit_flag, 1'b0, 300);
        // R8: matching data without strobe
        step(1'b0, 300, 1'b0);
        check("R8", hit_flag, 1'b0, 300);
        // R7: clear together with match -> set wins
        step(1'b1, 300, 1'b1);
        check("R7", hit_flag, 1'b1, 300);
        irq_en = 1'b1;
        #1 check("R9", irq_req, 1'b1, 300);
        irq_en = 1'b0;
        #1 check("R9", irq_req, 1'b0, 300);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule